// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Handover

This block turns a single PWM command into two gate enables for a synchronous buck power stage: one for the high-side switch and one for the low-side switch. It ensures that the two switches are never commanded on together. A gate is handed over to the opposite side only in two stages. First, the currently active enable is dropped. The block then waits until the digital sense flags show that both gates are below their turn-off threshold. After that, a fixed number of clock cycles must pass before the requested side is enabled.

The dead time therefore adapts to the real behaviour of the switches. A slow-falling gate stretches the handover, and no fixed count taken from the PWM edge is trusted. Two requests take priority over the PWM command. A shutdown request keeps both switches off. An overvoltage request steers the stage toward the low-side switch, which discharges the output. Both sense flags are synchronous digital inputs, and a flag value of 1 means "this gate is below its threshold".

Top module: `gate_handover`

## Requirements
- R1: `hs_en` and `ls_en` are never 1 in the same cycle.
- R2: `hs_en` rises only on the DELAY_CYC-th consecutive clock edge at which all of the following hold: the requested side is high, the request is unchanged from the previous edge, both enables are 0, and both `hs_below` and `ls_below` are 1. DELAY_CYC defaults to 5, which is 40 ns at an 8 ns clock.
- R3: `ls_en` rises under the same rule as R2 with the low side as the requested side.
- R4: Once a side's enable is 1, it stays 1 for as long as the requested side is unchanged and neither shutdown nor overvoltage is requested. Both sense flags are ignored during that time.
- R5: A shutdown request sampled at an edge makes both enables 0 after that edge. Shutdown overrides the PWM command and the overvoltage request.
- R6: Without shutdown, an overvoltage request makes the requested side low whatever `pwm_cmd` is. `hs_en` is 0 after the edge that samples the request, and `ls_en` then follows through the handover of R3. `pwm_cmd`=1 requests the high side and `pwm_cmd`=0 requests the low side.
- R7: When the requested side changes, the enable that is on drops after that edge. A change that arrives during a dead-time wait discards the cycles already counted, and the handover restarts toward the newly requested side.
- R8: If a sense flag stays 0, neither enable rises for as long as it stays 0, with no timeout. Once it returns to 1, the normal handover resumes.
- R9: During reset both enables are 0. After reset, neither enable rises until both sense flags report 1.
- R10: The dead-time parameter must be at least one cycle, and DELAY_CYC × CLK_NS must not exceed MAX_DELAY_NS (default 100 ns). Elaboration stops otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_cmd | input | 1 | 1 requests the high-side switch, 0 requests the low-side switch |
| hs_below | input | 1 | 1 when the high-side gate-to-phase voltage is below threshold |
| ls_below | input | 1 | 1 when the low-side gate voltage is below threshold |
| shdn_req | input | 1 | Shutdown: both switches off |
| ovp_req | input | 1 | Overvoltage: request the low-side switch |
| hs_en | output | 1 | High-side gate enable |
| ls_en | output | 1 | Low-side gate enable |

## Verification
The following properties are checked every cycle:
- the two enables never overlap;
- each rise of an enable was preceded by both sense flags reporting off and both enables low;
- an enable holds while its request stands;
- shutdown and overvoltage take effect after one edge;
- a stuck sense flag blocks any rise.

Some behaviours can only be shown by the bench scenarios. These are the exact length of the dead time counted from the last qualifying edge, the restart of the count when the command reverses mid-wait, recovery after a stuck flag is released, and the post-reset hold-off. The bench models each gate falling a random number of cycles after its enable drops and compares both enables with a behavioural model on every cycle.

// File: rtl/gh_pkg.sv
`timescale 1ns/1ps
package gh_pkg;
   typedef enum logic [1:0] {
      TGT_NONE = 2'd0,
      TGT_HIGH = 2'd1,
      TGT_LOW  = 2'd2
   } tgt_e;
endpackage

// File: rtl/gh_target_sel.sv
`timescale 1ns/1ps
// Resolves which switch is wanted this cycle and whether that wish is
// unchanged from the previous edge.
module gh_target_sel
   import gh_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic pwm_cmd,
   input  logic shdn_req,
   input  logic ovp_req,
   output tgt_e tgt,
   output logic tgt_steady
);
   tgt_e tgt_q;

   // shutdown beats overvoltage beats the PWM command
   always_comb begin
      if (shdn_req)     tgt = TGT_NONE;
      else if (ovp_req) tgt = TGT_LOW;
      else if (pwm_cmd) tgt = TGT_HIGH;
      else              tgt = TGT_LOW;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tgt_q <= TGT_NONE;
      else        tgt_q <= tgt;
   end

   assign tgt_steady = (tgt == tgt_q) && (tgt != TGT_NONE);
endmodule

// File: rtl/gh_dwell_timer.sv
`timescale 1ns/1ps
// Counts consecutive qualified edges; fire marks the DELAY_CYC-th one.
module gh_dwell_timer #(
   parameter int DELAY_CYC = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic qual,
   output logic fire
);
   generate
      if (DELAY_CYC == 1) begin : g_direct
         assign fire = qual;
      end else begin : g_count
         localparam int CNT_W = $clog2(DELAY_CYC);
         localparam logic [CNT_W-1:0] LAST = CNT_W'(DELAY_CYC - 1);
         logic [CNT_W-1:0] cnt;

         assign fire = qual && (cnt == LAST);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            cnt <= '0;
            else if (qual && !fire) cnt <= cnt + CNT_W'(1);
            else                   cnt <= '0;
         end

         // R2 / R3: the run counter never passes the dead-time length
         p_cnt_range_r2 : assert property (@(posedge clk) disable iff (!rst_n)
            int'(cnt) < DELAY_CYC)
            else $error("dwell counter out of range");
      end
   endgenerate
endmodule

// File: rtl/gh_enable_stage.sv
`timescale 1ns/1ps
// Registered gate enables: a side turns on only when the timer fires and
// holds while it remains the wanted side.
module gh_enable_stage
   import gh_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  tgt_e tgt,
   input  logic fire,
   output logic hs_en,
   output logic ls_en
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hs_en <= 1'b0;
         ls_en <= 1'b0;
      end else begin
         hs_en <= (tgt == TGT_HIGH) && (hs_en || fire);
         ls_en <= (tgt == TGT_LOW)  && (ls_en || fire);
      end
   end
endmodule

// File: rtl/gate_handover.sv
`timescale 1ns/1ps
module gate_handover
   import gh_pkg::*;
#(
   parameter int DELAY_CYC    = 5,
   parameter int CLK_NS       = 8,
   parameter int MAX_DELAY_NS = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pwm_cmd,
   input  logic hs_below,
   input  logic ls_below,
   input  logic shdn_req,
   input  logic ovp_req,
   output logic hs_en,
   output logic ls_en
);
   localparam int DELAY_NS = DELAY_CYC * CLK_NS;

   // R10: elaboration-time limits on the dead time
   generate
      if (DELAY_CYC < 1) begin : g_bad_min
         $error("DELAY_CYC must be at least 1");
      end
      if (DELAY_NS > MAX_DELAY_NS) begin : g_bad_max
         $error("dead time exceeds MAX_DELAY_NS");
      end
   endgenerate

   tgt_e tgt;
   logic tgt_steady;
   logic qual;
   logic fire;

   gh_target_sel i_sel (
      .clk        (clk),
      .rst_n      (rst_n),
      .pwm_cmd    (pwm_cmd),
      .shdn_req   (shdn_req),
      .ovp_req    (ovp_req),
      .tgt        (tgt),
      .tgt_steady (tgt_steady)
   );

   // both switches idle and both gates confirmed below threshold
   assign qual = tgt_steady && !hs_en && !ls_en && hs_below && ls_below;

   gh_dwell_timer #(.DELAY_CYC(DELAY_CYC)) i_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .qual  (qual),
      .fire  (fire)
   );

   gh_enable_stage i_stage (
      .clk   (clk),
      .rst_n (rst_n),
      .tgt   (tgt),
      .fire  (fire),
      .hs_en (hs_en),
      .ls_en (ls_en)
   );

   p_no_overlap_r1 : assert property (@(posedge clk) disable iff (!rst_n)
      !(hs_en && ls_en))
      else $error("both enables high");

   p_hs_rise_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hs_en) |-> ($past(ls_below) && $past(hs_below) && !$past(ls_en)))
      else $error("high side rose without low side confirmed off");

   p_ls_rise_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ls_en) |-> ($past(hs_below) && $past(ls_below) && !$past(hs_en)))
      else $error("low side rose without high side confirmed off");

   p_hs_hold_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      (hs_en && pwm_cmd && !shdn_req && !ovp_req) |=> hs_en)
      else $error("high side dropped while still wanted");

   p_ls_hold_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      (ls_en && !pwm_cmd && !shdn_req) |=> ls_en)
      else $error("low side dropped while still wanted");

   p_shdn_off_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      shdn_req |=> (!hs_en && !ls_en))
      else $error("enable active after shutdown");

   p_ovp_hs_off_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      ovp_req |=> !hs_en)
      else $error("high side active during overvoltage");

   p_stuck_block_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (!hs_en && !ls_below) |=> !hs_en)
      else $error("high side rose while low-side flag reports on");
endmodule

// File: tb/test_gate_handover.sv
`timescale 1ns/1ps
module test_gate_handover;
   localparam int D = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pwm_cmd = 1'b0;
   logic shdn_req = 1'b0;
   logic ovp_req = 1'b0;
   logic hs_below = 1'b1;
   logic ls_below = 1'b1;
   logic hs_en;
   logic ls_en;

   always #4 clk = ~clk;

   gate_handover #(.DELAY_CYC(D)) i_gate_handover (
      .clk      (clk),
      .rst_n    (rst_n),
      .pwm_cmd  (pwm_cmd),
      .hs_below (hs_below),
      .ls_below (ls_below),
      .shdn_req (shdn_req),
      .ovp_req  (ovp_req),
      .hs_en    (hs_en),
      .ls_en    (ls_en)
   );

   int  total = 0;
   int  bad = 0;
   bit  finished = 0;
   // behavioural reference state
   int  m_want_q = 0;   // 0 none, 1 high, 2 low
   int  m_run = 0;
   int  m_quiet = 0;
   bit  e_hs = 0, e_ls = 0, p_hs = 0, p_ls = 0;
   int  hs_tmr = 0, ls_tmr = 0;
   bit  frc_hs_low = 0, frc_ls_low = 0, noise_hs = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // one clock: drive sense flags, advance model, compare after the edge
   task automatic step();
      bit ho, lo, fire, q;
      int want;
      if (e_hs) begin hs_tmr = 1 + int'($urandom % 6); ho = 0; end
      else if (hs_tmr > 0) begin hs_tmr--; ho = 0; end
      else ho = 1;
      if (e_ls) begin ls_tmr = 1 + int'($urandom % 6); lo = 0; end
      else if (ls_tmr > 0) begin ls_tmr--; lo = 0; end
      else lo = 1;
      if (noise_hs && e_hs) ho = bit'($urandom % 2);
      if (frc_hs_low) ho = 0;
      if (frc_ls_low) lo = 0;
      hs_below = ho;
      ls_below = lo;

      want = shdn_req ? 0 : (ovp_req ? 2 : (pwm_cmd ? 1 : 2));
      m_quiet = (!e_hs && !e_ls && ho && lo) ? m_quiet + 1 : 0;
      q = (want != 0) && (want == m_want_q) && !e_hs && !e_ls && ho && lo;
      m_run = q ? m_run + 1 : 0;
      fire = (m_run == D);
      if (fire) m_run = 0;
      p_hs = e_hs;
      p_ls = e_ls;
      e_hs = (want == 1) && (e_hs || fire);
      e_ls = (want == 2) && (e_ls || fire);
      m_want_q = want;

      @(negedge clk);
      chk(hs_en === e_hs, "R2 high-side enable vs model", int'(hs_en), int'(e_hs));
      chk(ls_en === e_ls, "R3 low-side enable vs model", int'(ls_en), int'(e_ls));
      chk(!(hs_en && ls_en), "R1 enables overlap", int'(hs_en & ls_en), 0);
      if (hs_en && !p_hs) chk(m_quiet >= D, "R2 dead time before high side", m_quiet, D);
      if (ls_en && !p_ls) chk(m_quiet >= D, "R3 dead time before low side", m_quiet, D);
   endtask

   task automatic wait_hs_on();
      for (int i = 0; i < 60 && !hs_en; i++) step();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(hs_en === 1'b0 && ls_en === 1'b0, "R9 reset state", int'({hs_en, ls_en}), 0);
      // R9: flags held "on" after reset block everything
      frc_hs_low = 1; frc_ls_low = 1; pwm_cmd = 1;
      rst_n = 1'b1;
      for (int i = 0; i < 30; i++) begin
         step();
         chk(!hs_en && !ls_en, "R9 hold-off until flags report off", int'({hs_en, ls_en}), 0);
      end
      frc_hs_low = 0; frc_ls_low = 0;
      wait_hs_on();
      chk(hs_en === 1'b1, "R9 enable after flags released", int'(hs_en), 1);

      // normal random PWM traffic
      for (int i = 0; i < 600; i++) begin
         if ($urandom % 12 == 0) pwm_cmd = ~pwm_cmd;
         step();
      end

      // R7: reversal mid-wait restarts toward the new side
      pwm_cmd = 1; wait_hs_on();
      pwm_cmd = 0; step();
      chk(hs_en === 1'b0, "R7 on-side drops after request change", int'(hs_en), 0);
      step();
      pwm_cmd = 1;
      for (int i = 0; i < 40; i++) begin
         step();
         chk(ls_en === 1'b0, "R7 abandoned low side never enabled", int'(ls_en), 0);
      end
      chk(hs_en === 1'b1, "R7 handover resumes to high side", int'(hs_en), 1);

      // R4: sense noise while on has no effect
      noise_hs = 1;
      for (int i = 0; i < 60; i++) begin
         step();
         chk(hs_en === 1'b1, "R4 high side holds despite flag noise", int'(hs_en), 1);
      end
      noise_hs = 0;

      // R5: shutdown, partly together with overvoltage
      shdn_req = 1;
      for (int i = 0; i < 40; i++) begin
         pwm_cmd = bit'($urandom % 2);
         ovp_req = (i >= 20);
         step();
         chk(!hs_en && !ls_en, "R5 both off in shutdown", int'({hs_en, ls_en}), 0);
      end
      shdn_req = 0;

      // R6: overvoltage steers to the low side
      for (int i = 0; i < 80; i++) begin
         pwm_cmd = bit'($urandom % 2);
         step();
         chk(hs_en === 1'b0, "R6 high side off under overvoltage", int'(hs_en), 0);
      end
      chk(ls_en === 1'b1, "R6 low side on under overvoltage", int'(ls_en), 1);
      ovp_req = 0;

      // R8: stuck low-side flag blocks high side with no timeout
      pwm_cmd = 0;
      for (int i = 0; i < 30; i++) step();
      frc_ls_low = 1; pwm_cmd = 1;
      for (int i = 0; i < 300; i++) begin
         step();
         chk(hs_en === 1'b0, "R8 stuck flag blocks high side", int'(hs_en), 0);
      end
      frc_ls_low = 0;
      for (int i = 0; i < 30; i++) step();
      chk(hs_en === 1'b1, "R8 high side after flag recovers", int'(hs_en), 1);

      // mixed random traffic with priority requests
      for (int i = 0; i < 1500; i++) begin
         if ($urandom % 10 == 0) pwm_cmd = ~pwm_cmd;
         if ($urandom % 97 == 0) shdn_req = ~shdn_req;
         if ($urandom % 61 == 0) ovp_req = ~ovp_req;
         step();
      end

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(200000 * 8);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 0, 1);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule